// File: doc/BRIEF.md
# Grouped-Repetition Byte Stream Matcher

This block scans a byte stream, one character per qualified clock, for a pattern made of one lead character followed by a fixed group of literal characters repeated a bounded number of times. The default build looks for `d(abc){3,5}`. Each pattern character owns one state flip-flop, and the states form a nondeterministic chain in which more than one state may be live at a time. The chain produces two strobes: an increment when the group completes and a clear when the consecutive run of groups is broken. Both drive a repetition counter whose value sets a registered match flag.

The lead character, the group characters, the group length, the repetition bounds and an open-ended ("at least") mode are all parameters. A stream source drives `inValid` high with each new byte. Idle cycles leave the whole matcher frozen. Overlapping occurrences are not recovered: each run of groups is counted once, from the point where the chain was entered.

Top module: `grpmatch_top`

## Requirements
- R1: On a cycle with `inValid` low, no NFA state, the repetition count or `matchOut` changes.
- R2: Counting starts only when the first group character directly follows the lead character (`PREFIX_CHAR`, default 8'h64). A run of groups with no lead character before it never raises `matchOut`.
- R3: After a group completes, the next group may follow at once without a new lead character. Repetitions chain back to back.
- R4: In bounded mode (`AT_LEAST`=0), each completed group raises the count by one while the count is below `MAX_REP`.
- R5: Any accepted character that neither begins a group at a valid entry point nor continues the group at its expected position clears the count to zero and drops `matchOut` after that edge. This includes the group's own characters out of order and the lead character itself.
- R6: In bounded mode, `matchOut` is high exactly while the count lies in `[MIN_REP, MAX_REP]`. For the default `d(abc){3,5}` it is high for 3, 4 and 5 groups.
- R7: In bounded mode, a group that completes when the count already equals `MAX_REP` wraps the count to zero and drops `matchOut`. With `b(c){4}`, the stream `bccccc` gives exactly one cycle of match.
- R8: In open-ended mode (`AT_LEAST`=1), the count saturates at `MIN_REP` and `matchOut` stays high while the chain of groups is unbroken.
- R9: While `rstN` is low, `matchOut` is low and the count and all NFA states are zero.
- R10: `matchOut` is a register. It reflects the character accepted at a rising edge directly after that edge.
- R11: Group character j sits at bits `[8j+7:8j]` of `GROUP_CHARS`. Characters are 8-bit codes (ASCII for the defaults: a=8'h61, b=8'h62, c=8'h63).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Qualifies `inChar` for this cycle |
| inChar | input | 8 | Stream character |
| matchOut | output | 1 | Registered match flag |

## Verification
Every cycle, the assertions check how the strobes and the counter relate. Idle cycles must freeze all state. Increment and clear never fire together. The count steps by one, wraps at the upper bound or saturates in open-ended mode. `matchOut` agrees with the count's range, and the lead stage and the chain entry follow the accepted character. Whether a whole character sequence is matched correctly can only be shown by the bench scenarios. These cover lead-character gating, back-to-back chaining, out-of-order group characters and the single-pulse wrap in exact mode. Three parameter sets run against a character-level reference model.

// File: rtl/grpmatch_pkg.sv
package grpmatch_pkg;

  // Strobes passed from the NFA control to the repetition datapath
  typedef struct packed {
    logic step;   // a character was accepted this cycle
    logic incr;   // the group completed on this character
    logic clr;    // the consecutive group run broke on this character
  } repStrobe_t;

endpackage

// File: rtl/grpmatch_dec.sv
module grpmatch_dec #(
  parameter int NTAP = 4,
  parameter logic [8*NTAP-1:0] TAP_CHARS = '0
) (
  input  logic [7:0]      charIn,
  output logic [NTAP-1:0] taps
);

  // One decoded line per pattern position; each is the one-hot line of its character
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    assign taps[t] = (charIn == TAP_CHARS[8*t +: 8]);
  end

endmodule

// File: rtl/grpmatch_ctrl.sv
module grpmatch_ctrl
  import grpmatch_pkg::*;
#(
  parameter logic [7:0] PREFIX_CHAR = 8'h64,
  parameter int GROUP_LEN = 3,
  parameter logic [8*GROUP_LEN-1:0] GROUP_CHARS = 24'h636261
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [7:0]           inChar,
  output repStrobe_t           strobes,
  output logic                 prefixSt,
  output logic [GROUP_LEN-1:0] grpState
);

  localparam int NTAP = GROUP_LEN + 1;
  localparam logic [8*NTAP-1:0] TAPS = {GROUP_CHARS, PREFIX_CHAR};

  logic [NTAP-1:0]      taps;
  logic [GROUP_LEN-1:0] grpNext;
  logic                 entryLive;

  grpmatch_dec #(.NTAP(NTAP), .TAP_CHARS(TAPS)) uDec (
    .charIn(inChar),
    .taps  (taps)
  );

  // Chain entry: lead stage live, or the previous group just completed
  assign entryLive = prefixSt | grpState[GROUP_LEN-1];

  for (genvar j = 0; j < GROUP_LEN; j++) begin : g_chain
    if (j == 0) begin : g_head
      assign grpNext[j] = entryLive & taps[1];
    end else begin : g_body
      assign grpNext[j] = grpState[j-1] & taps[j+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prefixSt <= 1'b0;
      grpState <= '0;
    end else if (inValid) begin
      prefixSt <= taps[0];
      grpState <= grpNext;
    end
  end

  always_comb begin
    strobes.step = inValid;
    strobes.incr = inValid & grpNext[GROUP_LEN-1];
    // No group position survives this character: the run is broken
    strobes.clr  = inValid & ~(|grpNext);
  end

endmodule

// File: rtl/grpmatch_count.sv
module grpmatch_count
  import grpmatch_pkg::*;
#(
  parameter int MIN_REP = 3,
  parameter int MAX_REP = 5,
  parameter bit AT_LEAST = 1'b0,
  parameter int CNT_W = $clog2(MAX_REP + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  repStrobe_t       strobes,
  output logic [CNT_W-1:0] repCount,
  output logic             matchOut
);

  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_REP);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_REP);

  logic [CNT_W-1:0] cntStep;
  logic [CNT_W-1:0] cntNext;
  logic             matchNext;

  if (AT_LEAST) begin : g_least
    assign cntStep   = (repCount >= MIN_C) ? MIN_C : repCount + 1'b1;
    assign matchNext = (cntNext == MIN_C);
  end else begin : g_bound
    assign cntStep   = (repCount == MAX_C) ? '0 : repCount + 1'b1;
    assign matchNext = (cntNext >= MIN_C) && (cntNext <= MAX_C);
  end

  always_comb begin
    cntNext = repCount;
    if (strobes.clr)       cntNext = '0;
    else if (strobes.incr) cntNext = cntStep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      repCount <= '0;
      matchOut <= 1'b0;
    end else if (strobes.step) begin
      repCount <= cntNext;
      matchOut <= matchNext;
    end
  end

endmodule

// File: rtl/grpmatch_top.sv
module grpmatch_top
  import grpmatch_pkg::*;
#(
  parameter logic [7:0] PREFIX_CHAR = 8'h64,
  parameter int GROUP_LEN = 3,
  parameter logic [8*GROUP_LEN-1:0] GROUP_CHARS = 24'h636261,
  parameter int MIN_REP = 3,
  parameter int MAX_REP = 5,
  parameter bit AT_LEAST = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inChar,
  output logic       matchOut
);

  localparam int CNT_W = $clog2(MAX_REP + 1);

  repStrobe_t           strobes;
  logic                 prefixSt;
  logic [GROUP_LEN-1:0] grpState;
  logic [CNT_W-1:0]     repCount;

  grpmatch_ctrl #(
    .PREFIX_CHAR(PREFIX_CHAR),
    .GROUP_LEN  (GROUP_LEN),
    .GROUP_CHARS(GROUP_CHARS)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inChar  (inChar),
    .strobes (strobes),
    .prefixSt(prefixSt),
    .grpState(grpState)
  );

  grpmatch_count #(
    .MIN_REP (MIN_REP),
    .MAX_REP (MAX_REP),
    .AT_LEAST(AT_LEAST),
    .CNT_W   (CNT_W)
  ) uCount (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .repCount(repCount),
    .matchOut(matchOut)
  );

endmodule

// File: rtl/grpmatch_chk.sv
module grpmatch_chk
  import grpmatch_pkg::*;
#(
  parameter logic [7:0] PREFIX_CHAR = 8'h64,
  parameter int GROUP_LEN = 3,
  parameter int MIN_REP = 3,
  parameter int MAX_REP = 5,
  parameter bit AT_LEAST = 1'b0,
  parameter int CNT_W = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [7:0]           inChar,
  input logic                 matchOut,
  input repStrobe_t           strobes,
  input logic                 prefixSt,
  input logic [GROUP_LEN-1:0] grpState,
  input logic [CNT_W-1:0]     repCount
);

  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_REP);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_REP);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(grpState) && $stable(prefixSt) && $stable(repCount) && $stable(matchOut));

  // R2
  prefix_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (inChar == PREFIX_CHAR) |=> prefixSt);

  // R2
  prefix_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (inChar != PREFIX_CHAR) |=> !prefixSt);

  // R3
  chain_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !prefixSt && !grpState[GROUP_LEN-1] |=> !grpState[0]);

  // R4
  incr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !AT_LEAST && strobes.incr && (repCount != MAX_C) |=> repCount == $past(repCount) + 1'b1);

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clr |=> (repCount == '0) && !matchOut);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.incr && strobes.clr));

  // R6
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchOut == (AT_LEAST ? (repCount == MIN_C) : ((repCount >= MIN_C) && (repCount <= MAX_C))));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !AT_LEAST && strobes.incr && (repCount == MAX_C) |=> (repCount == '0) && !matchOut);

  // R8
  least_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    AT_LEAST && strobes.incr && (repCount == MIN_C) |=> (repCount == MIN_C) && matchOut);

  // R9
  reset_chk: assert property (@(posedge clk)
    !rstN |=> !matchOut && (repCount == '0) && (grpState == '0) && !prefixSt);

endmodule

bind grpmatch_top grpmatch_chk #(
  .PREFIX_CHAR(PREFIX_CHAR),
  .GROUP_LEN  (GROUP_LEN),
  .MIN_REP    (MIN_REP),
  .MAX_REP    (MAX_REP),
  .AT_LEAST   (AT_LEAST),
  .CNT_W      (CNT_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inChar  (inChar),
  .matchOut(matchOut),
  .strobes (strobes),
  .prefixSt(prefixSt),
  .grpState(grpState),
  .repCount(repCount)
);

// File: tb/grpmatch_top_tb.sv
module grpmatch_top_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [7:0] inChar;
  logic [2:0] matchV;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  // Instance 0: d(abc){3,5}
  grpmatch_top u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChar(inChar), .matchOut(matchV[0])
  );

  // Instance 1: b(c){4}
  grpmatch_top #(
    .PREFIX_CHAR(8'h62), .GROUP_LEN(1), .GROUP_CHARS(8'h63),
    .MIN_REP(4), .MAX_REP(4), .AT_LEAST(1'b0)
  ) u_dutSingle (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChar(inChar), .matchOut(matchV[1])
  );

  // Instance 2: d(abc){2,}
  grpmatch_top #(
    .MIN_REP(2), .MAX_REP(2), .AT_LEAST(1'b1)
  ) u_dutLeast (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChar(inChar), .matchOut(matchV[2])
  );

  // Reference model state, one set per instance
  int mCnt [3];
  int mExp [3];
  bit mLive[3];
  bit mPrev[3];
  bit mMatch[3];

  function automatic logic [7:0] pfxOf(int i);
    return (i == 1) ? 8'h62 : 8'h64;
  endfunction
  function automatic int lenOf(int i);
    return (i == 1) ? 1 : 3;
  endfunction
  function automatic logic [7:0] grpOf(int i, int j);
    if (i == 1) return 8'h63;
    return 8'h61 + 8'(j);
  endfunction
  function automatic int minOf(int i);
    return (i == 0) ? 3 : ((i == 1) ? 4 : 2);
  endfunction
  function automatic int maxOf(int i);
    return (i == 0) ? 5 : ((i == 1) ? 4 : 2);
  endfunction

  task automatic modelStep(input logic [7:0] ch);
    for (int i = 0; i < 3; i++) begin
      bit adv = 1'b0;
      if (mLive[i] && ch == grpOf(i, mExp[i])) adv = 1'b1;
      else if (!mLive[i] && mPrev[i] && ch == grpOf(i, 0)) begin
        adv = 1'b1;
        mExp[i] = 0;
      end
      if (adv) begin
        mLive[i] = 1'b1;
        mExp[i]++;
        if (mExp[i] == lenOf(i)) begin
          mExp[i] = 0;
          if (i == 2) mCnt[i] = (mCnt[i] >= minOf(i)) ? minOf(i) : mCnt[i] + 1;
          else        mCnt[i] = (mCnt[i] == maxOf(i)) ? 0 : mCnt[i] + 1;
        end
      end else begin
        mLive[i] = 1'b0;
        mExp[i]  = 0;
        mCnt[i]  = 0;
      end
      mPrev[i]  = (ch == pfxOf(i));
      mMatch[i] = (i == 2) ? (mCnt[i] == minOf(i))
                           : (mCnt[i] >= minOf(i) && mCnt[i] <= maxOf(i));
    end
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the rising edge that consumes it
  task automatic send(input logic v, input logic [7:0] ch, input string tag);
    inValid = v;
    inChar  = ch;
    @(posedge clk);
    #1;
    if (v) modelStep(ch);
    for (int i = 0; i < 3; i++) chk(matchV[i], mMatch[i], tag);
    @(negedge clk);
  endtask

  task automatic sendStr(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) send(1'b1, s[i], tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5EED_0A17);
    for (int i = 0; i < 3; i++) begin
      mCnt[i] = 0; mExp[i] = 0; mLive[i] = 0; mPrev[i] = 0; mMatch[i] = 0;
    end
    rstN    = 1'b0;
    inValid = 1'b0;
    inChar  = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(matchV[0], 1'b0, "R9 reset inst0");
    chk(matchV[1], 1'b0, "R9 reset inst1");
    chk(matchV[2], 1'b0, "R9 reset inst2");
    rstN = 1'b1;

    // R4: two groups after the lead, below the lower bound
    sendStr("xdabcabc", "R4");
    chk(matchV[0], 1'b0, "R4 two groups");
    // R3 / R10: third group chained directly, match visible right after the edge
    sendStr("abc", "R3");
    chk(matchV[0], 1'b1, "R3 chained third group");
    chk(matchV[0], 1'b1, "R10 match after completing edge");
    // R1: idle cycles freeze everything
    for (int k = 0; k < 4; k++) send(1'b0, 8'h7A, "R1");
    chk(matchV[0], 1'b1, "R1 idle hold");
    // R6: counts 4 and 5 stay in range
    sendStr("abcabc", "R6");
    chk(matchV[0], 1'b1, "R6 count five");
    // R7: sixth group wraps
    sendStr("abc", "R7");
    chk(matchV[0], 1'b0, "R7 wrap past upper bound");
    // R5: out-of-order group character clears
    sendStr("xdabcabcabca", "R5");
    chk(matchV[0], 1'b1, "R5 before break");
    send(1'b1, 8'h63, "R5");
    chk(matchV[0], 1'b0, "R5 out-of-order clears");
    // R5: lead character inside a run also clears
    sendStr("xdabcabcabc", "R5");
    send(1'b1, 8'h64, "R5");
    chk(matchV[0], 1'b0, "R5 lead char clears");
    // R2: no lead character, no match
    sendStr("xabcabcabcabc", "R2");
    chk(matchV[0], 1'b0, "R2 missing lead");
    // R7: b(c){4} with bccccc gives one match cycle
    sendStr("xbcccc", "R7");
    chk(matchV[1], 1'b1, "R7 exact four");
    send(1'b1, 8'h63, "R7");
    chk(matchV[1], 1'b0, "R7 fifth c drops");
    // R8: open-ended mode saturates and holds
    sendStr("xdabcabc", "R8");
    chk(matchV[2], 1'b1, "R8 reached minimum");
    sendStr("abcabcab", "R8");
    chk(matchV[2], 1'b1, "R8 held while chained");
    // R11: group bytes taken by position; bca order never counts
    sendStr("xdbcabcabca", "R11");
    chk(matchV[0], 1'b0, "R11 rotated group");

    // Constrained random token stream
    for (int t = 0; t < 3000; t++) begin
      int tok = $urandom_range(0, 11);
      if ($urandom_range(0, 7) == 0) send(1'b0, 8'(seedVal), "R1 random idle");
      case (tok)
        0, 1, 2, 3: sendStr("abc", "R6 random");
        4:          sendStr("d", "R6 random");
        5:          sendStr("a", "R5 random");
        6:          sendStr("b", "R5 random");
        7:          sendStr("c", "R5 random");
        8:          sendStr("x", "R5 random");
        9:          sendStr("dabc", "R3 random");
        default: begin
          int run = $urandom_range(1, 6);
          send(1'b1, 8'h62, "R7 random");
          for (int r = 0; r < run; r++) send(1'b1, 8'h63, "R7 random");
        end
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule